// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a small NOR-style flash store. A host issues write cycles (chip enable and write enable low together for one clock) carrying an address and a data byte. The controller decodes the multi-cycle unlock grammar into program, unlock-bypass program, sector erase, suspend and resume requests. It captures the address and data of the final cycle and runs a counter-timed internal operation against a register-file array.

While an operation runs, the ready output is low and array reads return a status byte instead of stored data. Bit 7 of the status byte is data polling and bit 6 toggles on each read. A sector erase has two phases. The first clears the sector to all zeros and the second sets it to all ones. The erase can be paused so that other sectors can be read or programmed, and then continued. The active-low reset input aborts any running operation and returns the sequencer to read mode. It leaves the array contents untouched, as non-volatile storage would.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `dout` is 0, the sequencer is in read mode, and array contents written before the reset are kept.
- R2: Four write cycles start a program: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (target address, data). `ready` goes low in the cycle after the fourth write and stays low for exactly PROG_CYC cycles.
- R3: Programming can only clear bits. The stored word becomes the old word AND the written data.
- R4: The unlock pair followed by (0x555, 0x20) enters bypass mode. In bypass mode, (any address, 0xA0) followed by (target, data) programs in two cycles. The sequencer stays in bypass mode afterwards, and reads return array data.
- R5: In bypass mode, (any, 0x90) followed by (any, 0x00) returns to read mode. After that, a two-cycle program attempt has no effect.
- R6: A write that does not match the expected step of a sequence returns the sequencer to read mode. A following data write then does not program.
- R7: Six write cycles start an erase: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (any address in the sector, 0x30). `ready` is low for PRE_CYC+ERASE_CYC cycles, and at the end every word of that sector reads 0xFF. Other sectors are unchanged. The sector is address bits [MEM_AW-1 : MEM_AW-SEC_W].
- R8: During the first PRE_CYC cycles of an erase, the sector is written to all zeros. A reset after that phase leaves the sector reading 0x00.
- R9: A reset during a program aborts it. `ready` is 1 right after the reset and the target word is unchanged.
- R10: A read during a running operation returns a status byte, not array data. Bit 7 is the complement of bit 7 of the data being programmed, and is 0 during an erase. Bit 6 is 0 on the first status read of an operation and inverts on each later status read. Bits 5..0 are 0.
- R11: A write of 0xB0 during a running erase suspends it, and `ready` is 1 from the next cycle. While suspended, erase counting is frozen, reads outside the erased sector return array data, and reads inside it return the status byte.
- R12: While suspended, a program outside the erased sector runs normally. A program inside the erased sector is dropped. A write of 0x30 in read mode resumes the erase, which runs only its remaining cycles.
- R13: While a program or an unsuspended erase is running, writes other than the suspend code do not advance the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset and abort |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address for commands and array access |
| din | input | DW | Write data |
| dout | output | DW | Registered read data or status byte |
| ready | output | 1 | High when no program or unsuspended erase runs |

## Verification
The hardest state to reach is a program running inside a suspended erase, followed by a resume. The erase counter must be frozen through both the suspend and the nested program, and must then finish with exactly the cycles it had left. The stimulus starts an erase and spends a known number of cycles on status reads. It then suspends, programs one word outside the sector and one inside it, and idles. After the resume, it counts the low `ready` cycles against the total minus the cycles already spent. A second hard case is the zero-filled sector left behind by a reset that lands after the preprogram phase. It is reached by timing the reset a few cycles past PRE_CYC.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   localparam logic [10:0] UNLOCK_ADDR_A   = 11'h555;
   localparam logic [10:0] UNLOCK_ADDR_B   = 11'h2AA;
   localparam logic [7:0]  KEY_A           = 8'hAA;
   localparam logic [7:0]  KEY_B           = 8'h55;
   localparam logic [7:0]  CMD_PROG        = 8'hA0;
   localparam logic [7:0]  CMD_BYPASS      = 8'h20;
   localparam logic [7:0]  CMD_ERASE_SETUP = 8'h80;
   localparam logic [7:0]  CMD_SECTOR      = 8'h30;
   localparam logic [7:0]  CMD_SUSPEND     = 8'hB0;
   localparam logic [7:0]  CMD_RESUME      = 8'h30;
   localparam logic [7:0]  CMD_EXIT_A      = 8'h90;
   localparam logic [7:0]  CMD_EXIT_B      = 8'h00;

   typedef enum logic [3:0] {
      SQ_READ,
      SQ_UNL1,
      SQ_UNL2,
      SQ_PGM,
      SQ_ER1,
      SQ_ER2,
      SQ_ER3,
      SQ_BYP,
      SQ_BYP_PGM,
      SQ_BYP_EXIT
   } seq_e;

   typedef enum logic [1:0] {
      ER_NONE,
      ER_PRE,
      ER_MAIN
   } erase_phase_e;

endpackage

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [10:0] cmd_addr,
   input  logic [7:0]  cmd_byte,
   input  logic        busy,
   input  logic        suspended,
   output seq_e        state,
   output logic        go_prog,
   output logic        go_erase,
   output logic        go_susp,
   output logic        go_resume
);

   seq_e state_q, state_d;
   logic at_a, key_a, key_b;

   assign at_a  = (cmd_addr == UNLOCK_ADDR_A);
   assign key_a = at_a && (cmd_byte == KEY_A);
   assign key_b = (cmd_addr == UNLOCK_ADDR_B) && (cmd_byte == KEY_B);

   always_comb begin
      state_d   = state_q;
      go_prog   = 1'b0;
      go_erase  = 1'b0;
      go_susp   = 1'b0;
      go_resume = 1'b0;
      if (wr) begin
         if (busy) begin
            go_susp = (cmd_byte == CMD_SUSPEND);
         end else begin
            case (state_q)
               SQ_READ: begin
                  if (key_a) state_d = SQ_UNL1;
                  else if (suspended && cmd_byte == CMD_RESUME) go_resume = 1'b1;
               end
               SQ_UNL1: state_d = key_b ? SQ_UNL2 : SQ_READ;
               SQ_UNL2: begin
                  state_d = SQ_READ;
                  if (at_a) begin
                     case (cmd_byte)
                        CMD_PROG:        state_d = SQ_PGM;
                        CMD_BYPASS:      state_d = SQ_BYP;
                        CMD_ERASE_SETUP: state_d = SQ_ER1;
                        default:         state_d = SQ_READ;
                     endcase
                  end
               end
               SQ_PGM: begin
                  go_prog = 1'b1;
                  state_d = SQ_READ;
               end
               SQ_ER1: state_d = key_a ? SQ_ER2 : SQ_READ;
               SQ_ER2: state_d = key_b ? SQ_ER3 : SQ_READ;
               SQ_ER3: begin
                  go_erase = (cmd_byte == CMD_SECTOR) && !suspended;
                  state_d  = SQ_READ;
               end
               SQ_BYP: begin
                  if (cmd_byte == CMD_PROG) state_d = SQ_BYP_PGM;
                  else if (cmd_byte == CMD_EXIT_A) state_d = SQ_BYP_EXIT;
               end
               SQ_BYP_PGM: begin
                  go_prog = 1'b1;
                  state_d = SQ_BYP;
               end
               SQ_BYP_EXIT: state_d = (cmd_byte == CMD_EXIT_B) ? SQ_READ : SQ_BYP;
               default: state_d = SQ_READ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_READ;
      else        state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
   import fcs_pkg::*;
#(
   parameter int DW        = 8,
   parameter int MEM_AW    = 6,
   parameter int SEC_W     = 2,
   parameter int PROG_CYC  = 8,
   parameter int PRE_CYC   = 12,
   parameter int ERASE_CYC = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_prog,
   input  logic              go_erase,
   input  logic              go_susp,
   input  logic              go_resume,
   input  logic [MEM_AW-1:0] wr_idx,
   input  logic [DW-1:0]     wr_val,
   output logic              busy,
   output logic              prog_run,
   output logic              erase_run,
   output logic              suspended,
   output logic [SEC_W-1:0]  erase_sec,
   output logic              prog_msb,
   output logic              pg_we,
   output logic [MEM_AW-1:0] pg_idx,
   output logic [DW-1:0]     pg_val,
   output logic              fill_we,
   output logic [SEC_W-1:0]  fill_sec,
   output logic [DW-1:0]     fill_val
);

   localparam int ER_MAX = (PRE_CYC > ERASE_CYC) ? PRE_CYC : ERASE_CYC;
   localparam int PCW    = $clog2(PROG_CYC + 1);
   localparam int ECW    = $clog2(ER_MAX + 1);

   logic               prog_q;
   logic [PCW-1:0]     pcnt_q;
   logic [MEM_AW-1:0]  pidx_q;
   logic [DW-1:0]      pval_q;
   erase_phase_e       phase_q;
   logic [ECW-1:0]     ecnt_q;
   logic [SEC_W-1:0]   esec_q;
   logic               susp_q;

   logic               erase_step, prog_ok, susp_ok, last_main;
   logic [SEC_W-1:0]   wr_sec;

   assign wr_sec     = wr_idx[MEM_AW-1 -: SEC_W];
   assign erase_step = (phase_q != ER_NONE) && !susp_q && !prog_q;
   assign last_main  = erase_step && (ecnt_q == '0) && (phase_q == ER_MAIN);
   assign prog_ok    = go_prog && !prog_q &&
                       !((phase_q != ER_NONE) && susp_q && (wr_sec == esec_q));
   assign susp_ok    = go_susp && erase_step && !last_main;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q  <= 1'b0;
         pcnt_q  <= '0;
         pidx_q  <= '0;
         pval_q  <= '0;
         phase_q <= ER_NONE;
         ecnt_q  <= '0;
         esec_q  <= '0;
         susp_q  <= 1'b0;
      end else begin
         if (prog_q) begin
            if (pcnt_q == '0) prog_q <= 1'b0;
            else              pcnt_q <= pcnt_q - 1'b1;
         end else if (prog_ok) begin
            prog_q <= 1'b1;
            pcnt_q <= PCW'(PROG_CYC - 1);
            pidx_q <= wr_idx;
            pval_q <= wr_val;
         end

         if (erase_step) begin
            if (ecnt_q == '0) begin
               if (phase_q == ER_PRE) begin
                  phase_q <= ER_MAIN;
                  ecnt_q  <= ECW'(ERASE_CYC - 1);
               end else begin
                  phase_q <= ER_NONE;
               end
            end else begin
               ecnt_q <= ecnt_q - 1'b1;
            end
         end else if (go_erase && phase_q == ER_NONE) begin
            phase_q <= ER_PRE;
            ecnt_q  <= ECW'(PRE_CYC - 1);
            esec_q  <= wr_sec;
         end

         if (susp_ok)                                 susp_q <= 1'b1;
         else if (go_resume && susp_q && !prog_q)     susp_q <= 1'b0;
         else if (phase_q == ER_NONE)                 susp_q <= 1'b0;
      end
   end

   assign busy      = prog_q || erase_step;
   assign prog_run  = prog_q;
   assign erase_run = (phase_q != ER_NONE);
   assign suspended = susp_q;
   assign erase_sec = esec_q;
   assign prog_msb  = pval_q[DW-1];
   assign pg_we     = prog_q && (pcnt_q == '0);
   assign pg_idx    = pidx_q;
   assign pg_val    = pval_q;
   assign fill_we   = erase_step && (ecnt_q == '0);
   assign fill_sec  = esec_q;
   assign fill_val  = (phase_q == ER_PRE) ? '0 : '1;

endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
   parameter int DW     = 8,
   parameter int MEM_AW = 6,
   parameter int SEC_W  = 2
) (
   input  logic              clk,
   input  logic              pg_we,
   input  logic [MEM_AW-1:0] pg_idx,
   input  logic [DW-1:0]     pg_val,
   input  logic              fill_we,
   input  logic [SEC_W-1:0]  fill_sec,
   input  logic [DW-1:0]     fill_val,
   input  logic [MEM_AW-1:0] rd_idx,
   output logic [DW-1:0]     rd_word
);

   localparam int DEPTH = 1 << MEM_AW;
   localparam int SEC_SHIFT = MEM_AW - SEC_W;

   logic [DW-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(i >> SEC_SHIFT);
      localparam logic [MEM_AW-1:0] MY_IDX = MEM_AW'(i);
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (fill_we && fill_sec == MY_SEC)      cell_q <= fill_val;
         else if (pg_we && pg_idx == MY_IDX)     cell_q <= cell_q & pg_val;
      end
      assign words[i] = cell_q;
   end

   assign rd_word = words[rd_idx];

endmodule

// File: rtl/fcs_rdpath.sv
module fcs_rdpath #(
   parameter int DW    = 8,
   parameter int SEC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [SEC_W-1:0] rd_sec,
   input  logic [DW-1:0]    rd_word,
   input  logic             prog_run,
   input  logic             erase_run,
   input  logic             suspended,
   input  logic [SEC_W-1:0] erase_sec,
   input  logic             prog_msb,
   output logic [DW-1:0]    dout
);

   logic          tog_q;
   logic          status_sel;
   logic [DW-1:0] status_w;
   logic [DW-1:0] dout_q;

   assign status_sel = prog_run || (erase_run && (!suspended || rd_sec == erase_sec));

   always_comb begin
      status_w    = '0;
      status_w[7] = prog_run ? ~prog_msb : 1'b0;
      status_w[6] = tog_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q  <= 1'b0;
         dout_q <= '0;
      end else begin
         if (!prog_run && !erase_run) tog_q <= 1'b0;
         if (rd) begin
            if (status_sel) begin
               dout_q <= status_w;
               tog_q  <= ~tog_q;
            end else begin
               dout_q <= rd_word;
            end
         end
      end
   end

   assign dout = dout_q;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcs_pkg::*;
#(
   parameter int AW        = 11,
   parameter int DW        = 8,
   parameter int MEM_AW    = 6,
   parameter int SEC_W     = 2,
   parameter int PROG_CYC  = 8,
   parameter int PRE_CYC   = 12,
   parameter int ERASE_CYC = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          ready
);

   if (AW < 11)                     begin : g_bad_aw  $error("AW must cover the unlock addresses"); end
   if (DW < 8)                      begin : g_bad_dw  $error("DW must hold a command byte"); end
   if (MEM_AW > AW || MEM_AW > 10)  begin : g_bad_mem $error("MEM_AW out of range"); end
   if (SEC_W < 1 || SEC_W >= MEM_AW) begin : g_bad_sec $error("SEC_W out of range"); end
   if (PROG_CYC < 1 || PRE_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc $error("cycle counts must be positive"); end

   logic              wr, rd;
   seq_e              seq_q;
   logic              go_prog, go_erase, go_susp, go_resume;
   logic              busy, prog_run, ers_run, ers_susp, prog_msb;
   logic [SEC_W-1:0]  ers_sec, fill_sec;
   logic              pg_we, fill_we;
   logic [MEM_AW-1:0] pg_idx;
   logic [DW-1:0]     pg_val, fill_val, rd_word;

   assign wr = !ce_n && !we_n;
   assign rd = !ce_n && !oe_n && we_n;

   fcs_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr),
      .cmd_addr  (addr[10:0]),
      .cmd_byte  (din[7:0]),
      .busy      (busy),
      .suspended (ers_susp),
      .state     (seq_q),
      .go_prog   (go_prog),
      .go_erase  (go_erase),
      .go_susp   (go_susp),
      .go_resume (go_resume)
   );

   fcs_engine #(
      .DW(DW), .MEM_AW(MEM_AW), .SEC_W(SEC_W),
      .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_prog   (go_prog),
      .go_erase  (go_erase),
      .go_susp   (go_susp),
      .go_resume (go_resume),
      .wr_idx    (addr[MEM_AW-1:0]),
      .wr_val    (din),
      .busy      (busy),
      .prog_run  (prog_run),
      .erase_run (ers_run),
      .suspended (ers_susp),
      .erase_sec (ers_sec),
      .prog_msb  (prog_msb),
      .pg_we     (pg_we),
      .pg_idx    (pg_idx),
      .pg_val    (pg_val),
      .fill_we   (fill_we),
      .fill_sec  (fill_sec),
      .fill_val  (fill_val)
   );

   fcs_array #(.DW(DW), .MEM_AW(MEM_AW), .SEC_W(SEC_W)) u_arr (
      .clk      (clk),
      .pg_we    (pg_we),
      .pg_idx   (pg_idx),
      .pg_val   (pg_val),
      .fill_we  (fill_we),
      .fill_sec (fill_sec),
      .fill_val (fill_val),
      .rd_idx   (addr[MEM_AW-1:0]),
      .rd_word  (rd_word)
   );

   fcs_rdpath #(.DW(DW), .SEC_W(SEC_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (rd),
      .rd_sec    (addr[MEM_AW-1 -: SEC_W]),
      .rd_word   (rd_word),
      .prog_run  (prog_run),
      .erase_run (ers_run),
      .suspended (ers_susp),
      .erase_sec (ers_sec),
      .prog_msb  (prog_msb),
      .dout      (dout)
   );

   assign ready = !busy;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
   import fcs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr,
   input logic       rd,
   input logic [7:0] cmd_byte,
   input logic [7:0] dout_lo,
   input logic       ready,
   input seq_e       seq_state,
   input logic       ers_run,
   input logic       ers_susp,
   input logic       prog_run,
   input logic       go_erase
);

   a_r13_seq_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !ready) |=> $stable(seq_state));

   a_r11_suspend_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_run && !ers_susp && !prog_run && wr && cmd_byte == CMD_SUSPEND) |=> ready);

   a_r10_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !ready) |=> (dout_lo[5:0] == 6'b0));

   a_r10_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !ready) ##1 (rd && !ready) |=> (dout_lo[6] != $past(dout_lo[6])));

   a_r7_erase_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      go_erase |-> ready);

endmodule

bind flash_cmd_ctrl fcs_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr        (wr),
   .rd        (rd),
   .cmd_byte  (din[7:0]),
   .dout_lo   (dout[7:0]),
   .ready     (ready),
   .seq_state (seq_q),
   .ers_run   (ers_run),
   .ers_susp  (ers_susp),
   .prog_run  (prog_run),
   .go_erase  (go_erase)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 11, DW = 8, MEM_AW = 6, SEC_W = 2;
   localparam int PROG_CYC = 8, PRE_CYC = 12, ERASE_CYC = 20;
   localparam int TOTAL_ER = PRE_CYC + ERASE_CYC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          ready;

   int n_chk = 0, n_fail = 0;
   logic [7:0] model [64];
   logic [7:0] exp_q [$];
   logic [7:0] mask_q [$];
   string      tag_q [$];
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_ctrl #(
      .AW(AW), .DW(DW), .MEM_AW(MEM_AW), .SEC_W(SEC_W),
      .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .dout(dout), .ready(ready)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read results once the registered data is out
   always @(posedge clk) begin
      if (!ce_n && !oe_n && we_n) begin
         #1;
         if (exp_q.size() == 0) begin
            chk("monitor underflow", 1, 0);
         end else begin
            logic [7:0] e, m;
            string t;
            e = exp_q.pop_front();
            m = mask_q.pop_front();
            t = tag_q.pop_front();
            chk(t, int'(dout & m), int'(e & m));
         end
      end
   end

   // all tasks are entered at a falling edge and return at a falling edge
   task automatic wr_cyc(input logic [AW-1:0] a, input logic [7:0] d);
      ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd_cyc(input logic [AW-1:0] a, input logic [7:0] e, input logic [7:0] m, input string t);
      exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
      ce_n = 1'b0; oe_n = 1'b0; addr = a;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic rd_model(input int idx, input string t);
      rd_cyc(AW'(idx), model[idx], 8'hFF, t);
   endtask

   task automatic unlock();
      wr_cyc(11'h555, 8'hAA);
      wr_cyc(11'h2AA, 8'h55);
   endtask

   task automatic prog4(input int idx, input logic [7:0] d);
      unlock();
      wr_cyc(11'h555, 8'hA0);
      wr_cyc(AW'(idx), d);
   endtask

   task automatic erase6(input int sec);
      unlock();
      wr_cyc(11'h555, 8'h80);
      unlock();
      wr_cyc(AW'(sec << 4), 8'h30);
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_reset();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      chk("watchdog", 1, 0);
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 ready after reset", int'(ready), 1);
      chk("R1 dout after reset", int'(dout), 0);

      // R7 erase every sector, time the first one
      erase6(0);
      wait_ready(n);
      chk("R7 erase busy cycles", n, TOTAL_ER);
      for (int s = 1; s < 4; s++) begin
         erase6(s);
         wait_ready(n);
      end
      for (int i = 0; i < 64; i++) model[i] = 8'hFF;
      rd_model(0, "R7 erased word 0");
      rd_model(47, "R7 erased word 47");

      // R2 four-cycle program and its duration
      prog4(5, 8'h3C);
      wait_ready(n);
      chk("R2 program busy cycles", n, PROG_CYC);
      model[5] = model[5] & 8'h3C;
      rd_model(5, "R2 programmed word");

      // R10 status with data bit 7 clear: polling bit reads 1
      prog4(7, 8'h7F);
      rd_cyc(11'd9, 8'h80, 8'hFF, "R10 status first read");
      rd_cyc(11'd9, 8'hC0, 8'hFF, "R10 status second read");
      wait_ready(n);
      model[7] = 8'h7F;

      // R3 AND semantics, R10 status with data bit 7 set
      prog4(5, 8'hF0);
      rd_cyc(11'd5, 8'h00, 8'hFF, "R10 status read a");
      rd_cyc(11'd5, 8'h40, 8'hFF, "R10 status read b");
      rd_cyc(11'd5, 8'h00, 8'hFF, "R10 status read c");
      wait_ready(n);
      model[5] = model[5] & 8'hF0;
      rd_model(5, "R3 bits only clear");

      // R4 bypass mode two-cycle program, stays in bypass
      unlock();
      wr_cyc(11'h555, 8'h20);
      wr_cyc(11'h000, 8'hA0);
      wr_cyc(11'h012, 8'hA5);
      chk("R4 bypass program starts", int'(ready), 0);
      wait_ready(n);
      model[18] = 8'hA5;
      rd_model(18, "R4 bypass read returns array");
      wr_cyc(11'h000, 8'hA0);
      wr_cyc(11'h013, 8'h0F);
      wait_ready(n);
      model[19] = 8'h0F;
      rd_model(19, "R4 second bypass program");

      // R5 exit bypass, then two-cycle program does nothing
      wr_cyc(11'h000, 8'h90);
      wr_cyc(11'h000, 8'h00);
      wr_cyc(11'h000, 8'hA0);
      wr_cyc(11'h014, 8'h00);
      chk("R5 no program after exit", int'(ready), 1);
      rd_model(20, "R5 word unchanged after exit");

      // R6 invalid command byte and invalid second unlock
      unlock();
      wr_cyc(11'h555, 8'h77);
      wr_cyc(11'h016, 8'h00);
      chk("R6 bad command no program", int'(ready), 1);
      rd_model(22, "R6 word unchanged bad command");
      wr_cyc(11'h555, 8'hAA);
      wr_cyc(11'h123, 8'h55);
      wr_cyc(11'h555, 8'hA0);
      wr_cyc(11'h017, 8'h00);
      chk("R6 bad unlock no program", int'(ready), 1);
      rd_model(23, "R6 word unchanged bad unlock");

      // R13 writes during a program are ignored
      prog4(9, 8'hFE);
      wr_cyc(11'h555, 8'hAA);
      wr_cyc(11'h2AA, 8'h55);
      wr_cyc(11'h555, 8'hA0);
      wait_ready(n);
      model[9] = 8'hFE;
      wr_cyc(11'h00A, 8'h00);
      chk("R13 busy writes dropped", int'(ready), 1);
      rd_model(10, "R13 word unchanged");
      rd_model(9, "R13 program itself done");

      // R11 / R12 suspend, nested program, resume
      prog4(33, 8'h00);
      wait_ready(n);
      model[33] = 8'h00;
      erase6(2);
      rd_cyc(11'd40, 8'h00, 8'hFF, "R10 erase status first");
      rd_cyc(11'd40, 8'h40, 8'hFF, "R10 erase status second");
      repeat (3) @(negedge clk);
      wr_cyc(11'h000, 8'hB0);
      chk("R11 ready after suspend", int'(ready), 1);
      rd_model(5, "R11 read outside erased sector");
      rd_cyc(11'd33, 8'h00, 8'hFF, "R11 status inside erased sector");
      prog4(6, 8'h81);
      chk("R12 program while suspended runs", int'(ready), 0);
      wait_ready(n);
      chk("R12 nested program cycles", n, PROG_CYC);
      model[6] = 8'h81;
      rd_model(6, "R12 nested program result");
      prog4(34, 8'h00);
      chk("R12 program in erased sector dropped", int'(ready), 1);
      repeat (10) @(negedge clk);
      chk("R11 erase frozen while suspended", int'(ready), 1);
      wr_cyc(11'h000, 8'h30);
      wait_ready(n);
      chk("R12 remaining erase cycles", n, TOTAL_ER - 6);
      for (int i = 32; i < 48; i++) model[i] = 8'hFF;
      rd_model(33, "R7 erased sector word");
      rd_model(34, "R12 dropped word erased");
      rd_model(6, "R7 other sector kept");

      // R9 reset aborts a program
      prog4(11, 8'h00);
      repeat (2) @(negedge clk);
      chk("R9 busy before reset", int'(ready), 0);
      pulse_reset();
      chk("R9 ready after abort", int'(ready), 1);
      rd_model(11, "R9 word unchanged");
      rd_model(5, "R1 array kept over reset");

      // R8 reset after preprogram leaves zeros
      erase6(3);
      repeat (PRE_CYC + 2) @(negedge clk);
      chk("R8 still busy", int'(ready), 0);
      pulse_reset();
      chk("R8 ready after abort", int'(ready), 1);
      for (int i = 48; i < 64; i++) model[i] = 8'h00;
      rd_model(50, "R8 preprogrammed zeros");
      rd_model(63, "R8 preprogrammed zeros last");

      repeat (3) @(negedge clk);
      chk("monitor queue drained", exp_q.size(), 0);
      finish_run();
   end

endmodule